// File: doc/BRIEF.md
# Write-Back Set-Associative Data Cache Controller

This block sits between a processor's load/store port and the next level of the memory hierarchy. It holds the tags, the valid and dirty state, the line data and the least-recently-used order for a set-associative cache of whole 32-byte lines. The cache uses write-back with write-allocate. A processor request is a read or write of one 32-bit word. A hit is answered in the cycle after the request is accepted. A miss is handled as one transaction at a time: a victim is picked in the indexed set, a dirty victim is first copied out to memory, the whole line holding the requested word is then fetched, and finally the access completes on the freshly filled line.

The memory side moves one complete line per transfer. The controller raises a request with a line-aligned address and a direction, and holds it until the memory answers with a one-cycle ready. On a read transfer, the returned line is taken in that same cycle. The default geometry is 8 ways by 256 sets of 32-byte lines on 32-bit addresses. The address splits into a 5-bit byte offset in the low bits, an 8-bit set index above it and a 19-bit tag in the top bits.

Top module: `wb_cache_ctrl`

## Requirements
- R1: After reset, `cpu_ready` is 1, `rsp_valid` is 0, `mem_req` is 0, and every line is invalid, so the first access to any address misses.
- R2: A read that hits gives `rsp_valid` with the stored word exactly one cycle after acceptance, with no memory transfer.
- R3: A write that hits replaces the word in the cached line and marks the line dirty with no memory transfer. The dirty mark shows later as a write-back when that line is evicted.
- R4: A miss whose victim is clean or invalid makes one read transfer (`mem_we`=0) at the line-aligned address of the request (offset bits zero). `rsp_valid` follows two cycles after the cycle in which `mem_ready` completes that transfer.
- R5: A miss whose victim is valid and dirty first makes one write transfer (`mem_we`=1) of the victim's line to the victim's own line-aligned address. It then makes the read transfer of R4 in the cycle right after the write-back completes.
- R6: A write miss fills the fetched line, puts the write word into it and marks it dirty. Any later write-back of a line carries every word written to it.
- R7: When the indexed set holds an invalid way, the victim is the lowest-numbered invalid way, and no valid line is evicted.
- R8: When every way of the set is valid, the victim is the way accessed least recently. Hits, filled read misses and filled write misses all count as accesses.
- R9: `cpu_ready` is 0 from the cycle after a missing request is accepted until its response cycle, and no request is taken in that time.
- R10: While `mem_req` is 1 and `mem_ready` is 0, `mem_req`, `mem_we` and `mem_addr` hold their values into the next cycle.
- R11: Address bits [4:2] select the word in a line, with word 0 at line bits [31:0]. Address bits [1:0] are ignored.
- R12: Each accepted request gives exactly one one-cycle `rsp_valid` pulse. A write's response returns the write data on `rsp_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_valid | input | 1 | Processor request present |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address of the word |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Controller can take a request (idle) |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DATA_W | Read word, or echoed write word |
| mem_req | output | 1 | Line transfer requested |
| mem_we | output | 1 | 1 = write-back, 0 = refill |
| mem_addr | output | ADDR_W | Line-aligned transfer address |
| mem_wdata | output | LINE_BYTES*8 | Victim line for write-back |
| mem_ready | input | 1 | Transfer done this cycle |
| mem_rdata | input | LINE_BYTES*8 | Refill line, valid with mem_ready |

## Verification
The properties assume that memory raises `mem_ready` only while `mem_req` is high, for a single cycle per transfer, and that a returned line is valid in that same cycle. They also assume that `cpu_valid` is a single-cycle pulse given while `cpu_ready` is high. The bench keeps to these assumptions as follows. It drives `cpu_valid` for one cycle at a time. Its memory model raises `mem_ready` only after it has seen a request, after a latency that varies from access to access, and drops it in the next cycle. The bench also keeps an independent model of set contents and access order, and uses it to predict hits, victims, write-back addresses and latency.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WRITEBACK = 2'd1,
        ST_REFILL    = 2'd2,
        ST_RESPOND   = 2'd3
    } wbc_state_e;

endpackage

// File: rtl/wbc_lru.sv
// Per-set recency order kept as an age per way: 0 = most recent,
// WAYS-1 = least recent. The ages of a set always form a permutation.
module wbc_lru #(
    parameter int SETS = 256,
    parameter int WAYS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(SETS)-1:0] idx,
    input  logic                    touch,
    input  logic [$clog2(WAYS)-1:0] touch_way,
    output logic [$clog2(WAYS)-1:0] oldest_way
);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAY_W-1:0] age_q [SETS][WAYS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else if (touch) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way) begin
                    age_q[idx][w] <= '0;
                end else if (age_q[idx][w] < age_q[idx][touch_way]) begin
                    age_q[idx][w] <= age_q[idx][w] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        oldest_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (age_q[idx][w] == WAY_W'(WAYS - 1)) begin
                oldest_way = WAY_W'(w);
            end
        end
    end

    logic unused_idx_w;
    assign unused_idx_w = (IDX_W == 0);

endmodule

// File: rtl/wbc_tag_store.sv
// Valid, dirty and tag state; reads all ways of one set, writes one way.
module wbc_tag_store #(
    parameter int SETS  = 256,
    parameter int WAYS  = 8,
    parameter int TAG_W = 19
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [$clog2(SETS)-1:0]         idx,
    output logic [WAYS-1:0]                 rd_valid,
    output logic [WAYS-1:0]                 rd_dirty,
    output logic [WAYS-1:0][TAG_W-1:0]      rd_tag,
    input  logic                            wr_en,
    input  logic [$clog2(WAYS)-1:0]         wr_way,
    input  logic                            wr_dirty,
    input  logic [TAG_W-1:0]                wr_tag
);
    logic [WAYS-1:0]        valid_q [SETS];
    logic [WAYS-1:0]        dirty_q [SETS];
    logic [TAG_W-1:0]       tag_q   [SETS][WAYS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
            end
        end else if (wr_en) begin
            valid_q[idx][wr_way] <= 1'b1;
            dirty_q[idx][wr_way] <= wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[idx][wr_way] <= wr_tag;
        end
    end

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_rd
            assign rd_tag[w] = tag_q[idx][w];
        end
    endgenerate

    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];

endmodule

// File: rtl/wbc_data_store.sv
// Line storage: one full line read and one full line write per cycle.
module wbc_data_store #(
    parameter int SETS   = 256,
    parameter int WAYS   = 8,
    parameter int LINE_W = 256
) (
    input  logic                    clk,
    input  logic [$clog2(SETS)-1:0] idx,
    input  logic [$clog2(WAYS)-1:0] way,
    output logic [LINE_W-1:0]       rd_line,
    input  logic                    wr_en,
    input  logic [LINE_W-1:0]       wr_line
);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int DEPTH = SETS * WAYS;

    logic [LINE_W-1:0]      line_q [DEPTH];
    logic [IDX_W+WAY_W-1:0] slot;

    assign slot    = {idx, way};
    assign rd_line = line_q[slot];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_q[slot] <= wr_line;
        end
    end

endmodule

// File: rtl/wb_cache_ctrl.sv
module wb_cache_ctrl
    import wbc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int WAYS       = 8,
    parameter int SETS       = 256
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cpu_valid,
    input  logic                      cpu_we,
    input  logic [ADDR_W-1:0]         cpu_addr,
    input  logic [DATA_W-1:0]         cpu_wdata,
    output logic                      cpu_ready,
    output logic                      rsp_valid,
    output logic [DATA_W-1:0]         rsp_rdata,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [LINE_BYTES*8-1:0]   mem_wdata,
    input  logic                      mem_ready,
    input  logic [LINE_BYTES*8-1:0]   mem_rdata
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int WORDS  = LINE_W / DATA_W;
    localparam int WSEL_W = $clog2(WORDS);
    localparam int BSEL_W = $clog2(DATA_W / 8);
    localparam int WAY_W  = $clog2(WAYS);

    typedef struct packed {
        wbc_state_e          st;
        logic [ADDR_W-1:0]   addr;
        logic                we;
        logic [DATA_W-1:0]   wdata;
        logic [WAY_W-1:0]    way;
        logic [TAG_W-1:0]    vtag;
        logic                rsp_valid;
        logic [DATA_W-1:0]   rsp_rdata;
    } ctrl_t;

    ctrl_t q, d;

    // Address being looked up this cycle
    logic [ADDR_W-1:0] cur_addr;
    logic [IDX_W-1:0]  cur_idx;
    logic [TAG_W-1:0]  cur_tag;
    logic [WSEL_W-1:0] cur_wsel;

    assign cur_addr = (q.st == ST_IDLE) ? cpu_addr : q.addr;
    assign cur_idx  = cur_addr[OFF_W +: IDX_W];
    assign cur_tag  = cur_addr[ADDR_W-1 -: TAG_W];
    assign cur_wsel = cur_addr[BSEL_W +: WSEL_W];

    // Storage
    logic [WAYS-1:0]            rd_valid;
    logic [WAYS-1:0]            rd_dirty;
    logic [WAYS-1:0][TAG_W-1:0] rd_tag;
    logic [LINE_W-1:0]          rd_line;
    logic                       tag_we;
    logic                       tag_dirty;
    logic                       data_we;
    logic [LINE_W-1:0]          data_line;
    logic                       lru_touch;
    logic [WAY_W-1:0]           lru_oldest;
    logic [WAY_W-1:0]           act_way;

    // Lookup results
    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic             inv_any;
    logic [WAY_W-1:0] inv_way;
    logic [WAY_W-1:0] victim;

    assign act_way = (q.st == ST_IDLE) ? hit_way : q.way;

    wbc_tag_store #(
        .SETS  (SETS),
        .WAYS  (WAYS),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (cur_idx),
        .rd_valid (rd_valid),
        .rd_dirty (rd_dirty),
        .rd_tag   (rd_tag),
        .wr_en    (tag_we),
        .wr_way   (act_way),
        .wr_dirty (tag_dirty),
        .wr_tag   (cur_tag)
    );

    wbc_data_store #(
        .SETS   (SETS),
        .WAYS   (WAYS),
        .LINE_W (LINE_W)
    ) u_data (
        .clk     (clk),
        .idx     (cur_idx),
        .way     (act_way),
        .rd_line (rd_line),
        .wr_en   (data_we),
        .wr_line (data_line)
    );

    wbc_lru #(
        .SETS (SETS),
        .WAYS (WAYS)
    ) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (cur_idx),
        .touch      (lru_touch),
        .touch_way  (act_way),
        .oldest_way (lru_oldest)
    );

    function automatic logic [LINE_W-1:0] put_word(
        input logic [LINE_W-1:0] line,
        input logic [WSEL_W-1:0] sel,
        input logic [DATA_W-1:0] word
    );
        logic [LINE_W-1:0] r;
        r = line;
        r[sel*DATA_W +: DATA_W] = word;
        return r;
    endfunction

    // Tag compare and victim choice
    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (rd_valid[w] && (rd_tag[w] == cur_tag)) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
        inv_any = 1'b0;
        inv_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!rd_valid[w]) begin
                inv_any = 1'b1;
                inv_way = WAY_W'(w);
            end
        end
        victim = inv_any ? inv_way : lru_oldest;
    end

    // Next-state logic
    always_comb begin
        d           = q;
        d.rsp_valid = 1'b0;
        cpu_ready   = (q.st == ST_IDLE);
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = '0;
        mem_wdata   = '0;
        tag_we      = 1'b0;
        tag_dirty   = 1'b0;
        data_we     = 1'b0;
        data_line   = rd_line;
        lru_touch   = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                if (cpu_valid) begin
                    d.addr  = cpu_addr;
                    d.we    = cpu_we;
                    d.wdata = cpu_wdata;
                    if (hit) begin
                        d.rsp_valid = 1'b1;
                        lru_touch   = 1'b1;
                        if (cpu_we) begin
                            data_we     = 1'b1;
                            data_line   = put_word(rd_line, cur_wsel, cpu_wdata);
                            tag_we      = 1'b1;
                            tag_dirty   = 1'b1;
                            d.rsp_rdata = cpu_wdata;
                        end else begin
                            d.rsp_rdata = rd_line[cur_wsel*DATA_W +: DATA_W];
                        end
                    end else begin
                        d.way  = victim;
                        d.vtag = rd_tag[victim];
                        d.st   = (rd_valid[victim] && rd_dirty[victim]) ?
                                 ST_WRITEBACK : ST_REFILL;
                    end
                end
            end
            ST_WRITEBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {q.vtag, cur_idx, {OFF_W{1'b0}}};
                mem_wdata = rd_line;
                if (mem_ready) begin
                    d.st = ST_REFILL;
                end
            end
            ST_REFILL: begin
                mem_req  = 1'b1;
                mem_addr = {cur_tag, cur_idx, {OFF_W{1'b0}}};
                if (mem_ready) begin
                    data_we   = 1'b1;
                    data_line = q.we ? put_word(mem_rdata, cur_wsel, q.wdata)
                                     : mem_rdata;
                    tag_we    = 1'b1;
                    tag_dirty = q.we;
                    d.st      = ST_RESPOND;
                end
            end
            ST_RESPOND: begin
                d.rsp_valid = 1'b1;
                d.rsp_rdata = q.we ? q.wdata : rd_line[cur_wsel*DATA_W +: DATA_W];
                lru_touch   = 1'b1;
                d.st        = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rsp_valid = q.rsp_valid;
    assign rsp_rdata = q.rsp_rdata;

endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_valid,
    input logic              cpu_ready,
    input logic              rsp_valid,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr
);
    localparam int OFF_W = $clog2(LINE_BYTES);

    // R1: idle and quiet on the first edge after reset release
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cpu_ready && !mem_req && !rsp_valid));

    // R9: no request is taken while a transfer is in progress
    p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready);

    // R10: a pending transfer holds its request
    p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R4: transfers are line aligned
    p_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[OFF_W-1:0] == '0));

    // R4: response two cycles after the refill completes
    p_refill_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ready) |=> !rsp_valid ##1 rsp_valid);

    // R5: a finished write-back is followed at once by the refill
    p_wb_then_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ready) |=> (mem_req && !mem_we));

    // R12: a response follows an acceptance or the end of a miss
    p_rsp_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(cpu_valid && cpu_ready) || !$past(cpu_ready)));

endmodule

bind wb_cache_ctrl wbc_checker #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_valid (cpu_valid),
    .cpu_ready (cpu_ready),
    .rsp_valid (rsp_valid),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr)
);

// File: tb/wb_cache_ctrl_tb.sv
module wb_cache_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TB_WAYS    = 4;
    localparam int TB_SETS    = 4;
    localparam int NBLK       = 64;
    localparam int LINE_W     = 256;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_valid = 1'b0;
    logic              cpu_we = 1'b0;
    logic [31:0]       cpu_addr = '0;
    logic [31:0]       cpu_wdata = '0;
    logic              cpu_ready;
    logic              rsp_valid;
    logic [31:0]       rsp_rdata;
    logic              mem_req;
    logic              mem_we;
    logic [31:0]       mem_addr;
    logic [LINE_W-1:0] mem_wdata;
    logic              mem_ready = 1'b0;
    logic [LINE_W-1:0] mem_rdata = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wb_cache_ctrl #(
        .ADDR_W     (32),
        .DATA_W     (32),
        .LINE_BYTES (32),
        .WAYS       (TB_WAYS),
        .SETS       (TB_SETS)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_valid (cpu_valid),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_ready (cpu_ready),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // Reference model: flat memory image, backing store, set contents
    logic [LINE_W-1:0] gold    [NBLK];
    logic [LINE_W-1:0] backing [NBLK];
    bit                m_valid [TB_SETS][TB_WAYS];
    bit                m_dirty [TB_SETS][TB_WAYS];
    int                m_blk   [TB_SETS][TB_WAYS];
    int                m_use   [TB_SETS][TB_WAYS];
    int                tick = 0;
    logic [31:0]       rng = 32'h1357_9BDF;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rng(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic do_access(input bit we, input int b, input int w, input int bt,
                             input logic [31:0] wd, input int lat);
        int          s;
        int          hw;
        int          vw;
        bit          had_inv;
        bit          exp_wb;
        int          wb_blk;
        int          exp_cyc;
        int          exp_ntx;
        logic [31:0] exp_rd;
        logic [LINE_W-1:0] wb_line;
        string       lbl;
        int          cyc;
        bit          done;
        int          ntx;
        bit          inflight;
        int          wcnt;
        bit          bad_ready;
        bit          bad_hold;
        bit          t_we   [4];
        logic [31:0] t_addr [4];
        logic [LINE_W-1:0] t_data [4];

        s  = b % TB_SETS;
        hw = -1;
        for (int i = 0; i < TB_WAYS; i++)
            if (m_valid[s][i] && m_blk[s][i] == b) hw = i;
        vw = -1;
        had_inv = 1'b0;
        if (hw < 0) begin
            for (int i = TB_WAYS - 1; i >= 0; i--)
                if (!m_valid[s][i]) begin vw = i; had_inv = 1'b1; end
            if (!had_inv) begin
                vw = 0;
                for (int i = 1; i < TB_WAYS; i++)
                    if (m_use[s][i] < m_use[s][vw]) vw = i;
            end
        end
        exp_wb  = (hw < 0) && m_valid[s][vw] && m_dirty[s][vw];
        wb_blk  = (hw < 0) ? m_blk[s][vw] : 0;
        wb_line = gold[wb_blk];
        exp_cyc = (hw >= 0) ? 1 : (exp_wb ? 4 + 2 * lat : 3 + lat);
        exp_ntx = (hw >= 0) ? 0 : (exp_wb ? 2 : 1);
        exp_rd  = we ? wd : gold[b][w*32 +: 32];
        lbl     = (hw >= 0) ? (we ? "R3" : "R2") : (had_inv ? "R7" : "R8");

        if (we) gold[b][w*32 +: 32] = wd;
        tick++;
        if (hw >= 0) begin
            if (we) m_dirty[s][hw] = 1'b1;
            m_use[s][hw] = tick;
        end else begin
            m_valid[s][vw] = 1'b1;
            m_blk[s][vw]   = b;
            m_dirty[s][vw] = we;
            m_use[s][vw]   = tick;
        end

        @(negedge clk);
        cpu_valid = 1'b1;
        cpu_we    = we;
        cpu_addr  = 32'(b * 32 + w * 4 + bt);
        cpu_wdata = wd;
        cyc = 0; done = 1'b0; ntx = 0; inflight = 1'b0; wcnt = 0;
        bad_ready = 1'b0; bad_hold = 1'b0;
        while (!done && cyc < 64) begin
            @(negedge clk);
            cyc++;
            cpu_valid = 1'b0;
            mem_ready = 1'b0;
            if (rsp_valid) begin
                done = 1'b1;
            end else begin
                if (cpu_ready) bad_ready = 1'b1;
                if (mem_req && !inflight && ntx < 4) begin
                    t_we[ntx]   = mem_we;
                    t_addr[ntx] = mem_addr;
                    t_data[ntx] = mem_wdata;
                    if (mem_we) backing[mem_addr[10:5]] = mem_wdata;
                    ntx++;
                    inflight = 1'b1;
                    wcnt = lat;
                end else if (inflight && (!mem_req || mem_addr != t_addr[ntx-1])) begin
                    bad_hold = 1'b1;
                end
                if (inflight) begin
                    if (wcnt == 0) begin
                        mem_rdata = backing[t_addr[ntx-1][10:5]];
                        mem_ready = 1'b1;
                        inflight  = 1'b0;
                    end else begin
                        wcnt--;
                    end
                end
            end
        end

        check(done, "R12", "response seen", LINE_W'(done), 1);
        check(cyc == exp_cyc, (hw < 0 && ntx > 0) ? "R4" : lbl, "latency cycles",
              LINE_W'(cyc), LINE_W'(exp_cyc));
        check(ntx == exp_ntx, (hw >= 0) ? lbl : (exp_wb ? "R3" : lbl), "transfer count",
              LINE_W'(ntx), LINE_W'(exp_ntx));
        if (hw < 0) begin
            check(!bad_ready, "R9", "cpu_ready low during miss", LINE_W'(bad_ready), 0);
            check(!bad_hold, "R10", "request held until ready", LINE_W'(bad_hold), 0);
        end
        if (exp_wb && ntx == 2) begin
            check(t_we[0] == 1'b1, "R5", "write-back direction", LINE_W'(t_we[0]), 1);
            check(t_addr[0] == 32'(wb_blk * 32), "R5", "write-back address",
                  LINE_W'(t_addr[0]), LINE_W'(wb_blk * 32));
            check(t_data[0] == wb_line, "R6", "write-back line", t_data[0], wb_line);
        end
        if (hw < 0 && ntx >= 1) begin
            check(!t_we[ntx-1] && t_addr[ntx-1] == 32'(b * 32), "R4", "refill address",
                  LINE_W'(t_addr[ntx-1]), LINE_W'(b * 32));
        end
        check(rsp_rdata == exp_rd, we ? "R12" : "R11", "response data",
              LINE_W'(rsp_rdata), LINE_W'(exp_rd));
        @(negedge clk);
        check(!rsp_valid, "R12", "single response pulse", LINE_W'(rsp_valid), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R12 watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int seq [9] = '{2, 0, 3, 1, 5, 0, 6, 2, 1};
        for (int b = 0; b < NBLK; b++) begin
            for (int w = 0; w < 8; w++) begin
                gold[b][w*32 +: 32] = 32'hC0DE_0000 | 32'(b << 4) | 32'(w);
            end
            backing[b] = gold[b];
        end
        for (int s = 0; s < TB_SETS; s++)
            for (int w = 0; w < TB_WAYS; w++) begin
                m_valid[s][w] = 1'b0; m_dirty[s][w] = 1'b0;
                m_blk[s][w] = -1;     m_use[s][w] = 0;
            end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check(cpu_ready == 1'b1, "R1", "cpu_ready after reset", LINE_W'(cpu_ready), 1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", LINE_W'(rsp_valid), 0);
        check(mem_req == 1'b0, "R1", "mem_req after reset", LINE_W'(mem_req), 0);

        // R1 R7: fill every way of every set, then revisit (all hits)
        for (int b = 0; b < 16; b++) do_access(1'b0, b, b % 8, b % 4, '0, b % 3);
        for (int b = 0; b < 16; b++) do_access(1'b0, b, (b + 3) % 8, 0, '0, 0);

        // R8: recency order within each set, mixed reads and writes
        for (int s = 0; s < TB_SETS; s++)
            for (int i = 0; i < 9; i++)
                do_access(i % 3 == 0, s + 4 * seq[i], i % 8, i % 4,
                          32'hA000_0000 | 32'(s * 16 + i), i % 3);

        // R3 R6 R11: every word of a group of lines, varied byte offsets
        for (int b = 16; b < 24; b++)
            for (int w = 0; w < 8; w++)
                do_access(1'b1, b, w, (b + w) % 4, 32'h5500_0000 | 32'(b * 8 + w), w % 3);

        // R5: sweep all lines so dirty ones are written back
        for (int b = 0; b < NBLK; b++) do_access(1'b0, b, (b * 3) % 8, 3, '0, b % 3);

        // Mixed traffic over all lines
        for (int i = 0; i < 1500; i++) begin
            logic [31:0] r1;
            logic [31:0] r2;
            rng = next_rng(rng); r1 = rng;
            rng = next_rng(rng); r2 = rng;
            do_access(r1[0], int'(r1[6:1]), int'(r1[9:7]), int'(r1[11:10]), r2,
                      int'(r1[13:12]) % 3);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule